// File: doc/BRIEF.md
# GPIO Bank Register File with Password-Guarded Write Locks

This block is the register file for a group of general-purpose I/O banks, each 32 pins wide, with between one and eight banks. A 32-bit register bus reads and writes it. Every pin has a direction word. Every bank has an output-value readback, a synchronized input readback, a set-bits port and a clear-bits port. The block drives the pin output values and output enables, and it samples the pin inputs through a two-flop synchronizer.

Each bank also has a lock word with one bit per pin. A pin whose lock bit is 1 ignores direction, set and clear writes aimed at it. The lock word is protected in turn. It takes a new value only when the bus access immediately before the lock write was a write of the unlock key to the key register. That key arms exactly one lock write, and any other access in between throws it away. Software unlocks a pin once before using it and locks it again when it releases the pin.

Top module: `gpio_lockbank_regs`

## Requirements
- R1: After reset, every pin is an input (`pin_oe` all 0), every output value is 0, every lock bit is 1 and `bus_rdata` is 0.
- R2: A write of 0x00a5a501 to word address 0x520 arms the lock path. The next bus access, if it is a write to 0x500 + 4*bank, replaces that bank's lock word with the written data. The lock path is then disarmed, so a second lock write without a fresh key write is dropped.
- R3: A lock write whose preceding access was not the key write (a read, any other write, or a key write with the wrong value) leaves the lock word unchanged.
- R4: Reading 0x500 + 4*bank returns that bank's lock word. Bit k set means pin 32*bank + k is locked.
- R5: The direction word of pin p is at 0x100 + 4*p. Pin p belongs to bank p>>5 at bit p&31. Bit 0 set to 1 makes the pin an input and 0 makes it an output, and `pin_oe[p]` is the inverse of that bit. A read returns the bit in position 0 with zeros above it.
- R6: A write to 0x40 + 4*bank drives high every pin whose data bit is 1. A 0 bit leaves its pin unchanged.
- R7: A write to 0x60 + 4*bank drives low every pin whose data bit is 1. A 0 bit leaves its pin unchanged.
- R8: Reading 0x00 + 4*bank returns the bank's output values. Writes to that address change nothing.
- R9: Reading 0x20 + 4*bank returns `pin_in` through two synchronizer flops. A read issued on the first bus slot after a pin change still returns the old value, and the next slot returns the new one.
- R10: Direction, set and clear writes leave locked pins unchanged, while reads of locked pins still return their current state.
- R11: `bus_rdata` updates on the clock edge that takes a read and holds between reads. Reads of unmapped addresses, of the key register and of the set/clear ports return 0. Writes to unmapped addresses have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | Bus access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | 32*NUM_BANKS | Asynchronous pin input levels |
| pin_out | output | 32*NUM_BANKS | Pin output values |
| pin_oe | output | 32*NUM_BANKS | Pin output enables, 1 = driving |

## Verification
The bench tries to slip a lock change past the key in three ways: with a read in between, with a wrong key value, and with a second lock write on a single key. A design with a sticky or level-sensitive arm would let pins be unlocked by stray traffic. A partially locked bank then gets set and clear words that cover both locked and free bits. A design that gates a whole bank on any lock bit, or that forgets the lock on one of the three write paths, would move the wrong pins. Input status is read on the slot right after a pin change and again one slot later. This catches a synchronizer that is one flop short or one flop long. Random key, lock, direction and output traffic is compared against a bench model.

// File: rtl/gpio_lockbank_pkg.sv
package gpio_lockbank_pkg;
  localparam int unsigned ADDR_W        = 12;
  localparam int unsigned PINS_PER_BANK = 32;
  localparam int unsigned IDX_W         = 8;
  localparam logic [31:0] UNLOCK_KEY    = 32'h00a5a501;
  localparam logic [ADDR_W-1:0] KEY_ADDR = 12'h520;
  localparam logic [ADDR_W-1:0] CTRL_LO  = 12'h100;
  localparam logic [ADDR_W-1:0] CTRL_HI  = 12'h500;

  typedef enum logic [2:0] {
    RK_NONE, RK_OUTST, RK_INST, RK_SET, RK_CLR, RK_CTRL, RK_LOCK, RK_KEY
  } reg_kind_e;

  typedef struct packed {
    reg_kind_e        kind;
    logic [IDX_W-1:0] idx;   // bank number, or pin number for RK_CTRL
  } reg_sel_t;

  // Address map decode; anything outside the populated banks is RK_NONE.
  function automatic reg_sel_t decode_addr(input logic [ADDR_W-1:0] a,
                                           input int unsigned nbanks);
    reg_sel_t s;
    logic [8:0] pin;
    s.kind = RK_NONE;
    s.idx  = '0;
    pin    = a[10:2] - 9'd64;
    if (a[11:7] == 5'b0) begin
      s.idx = {5'b0, a[4:2]};
      if (32'(a[4:2]) < nbanks) begin
        case (a[6:5])
          2'd0:    s.kind = RK_OUTST;
          2'd1:    s.kind = RK_INST;
          2'd2:    s.kind = RK_SET;
          default: s.kind = RK_CLR;
        endcase
      end
    end else if (a >= CTRL_LO && a < CTRL_HI) begin
      s.idx = pin[7:0];
      if (32'(pin) < nbanks * PINS_PER_BANK) s.kind = RK_CTRL;
    end else if (a[11:5] == 7'h28) begin
      s.idx = {5'b0, a[4:2]};
      if (32'(a[4:2]) < nbanks) s.kind = RK_LOCK;
    end else if (a[11:2] == KEY_ADDR[11:2]) begin
      s.kind = RK_KEY;
    end
    return s;
  endfunction

  function automatic logic [2:0] pin_bank(input logic [IDX_W-1:0] p);
    return p[7:5];
  endfunction

  function automatic logic [4:0] pin_pos(input logic [IDX_W-1:0] p);
    return p[4:0];
  endfunction

  // Set and clear only reach unlocked pins.
  function automatic logic [31:0] apply_set(input logic [31:0] cur,
                                            input logic [31:0] mask,
                                            input logic [31:0] lock);
    return cur | (mask & ~lock);
  endfunction

  function automatic logic [31:0] apply_clr(input logic [31:0] cur,
                                            input logic [31:0] mask,
                                            input logic [31:0] lock);
    return cur & ~(mask & ~lock);
  endfunction
endpackage

// File: rtl/gpio_lockbank_guard.sv
module gpio_lockbank_guard
  import gpio_lockbank_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 8
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            acc,
  input  logic                            wr,
  input  reg_sel_t                        sel,
  input  logic [31:0]                     wdata,
  output logic [NUM_BANKS*PINS_PER_BANK-1:0] lock_bits,
  output logic                            armed,
  output logic                            lock_take,
  output logic                            lock_drop
);
  localparam int unsigned NP = NUM_BANKS * PINS_PER_BANK;

  logic          armed_q;
  logic [NP-1:0] lock_q;
  logic          key_hit, lock_try;

  assign key_hit   = acc && wr && (sel.kind == RK_KEY) && (wdata == UNLOCK_KEY);
  assign lock_try  = acc && wr && (sel.kind == RK_LOCK);
  assign lock_take = lock_try && armed_q;
  assign lock_drop = lock_try && !armed_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      lock_q  <= '1;
    end else begin
      if (acc) armed_q <= key_hit;   // one-shot: every access re-evaluates
      for (int b = 0; b < NUM_BANKS; b++) begin
        if (lock_take && sel.idx == IDX_W'(b))
          lock_q[b*PINS_PER_BANK +: PINS_PER_BANK] <= wdata;
      end
    end
  end

  assign lock_bits = lock_q;
  assign armed     = armed_q;
endmodule

// File: rtl/gpio_lockbank_bank.sv
module gpio_lockbank_bank
  import gpio_lockbank_pkg::*;
#(
  parameter int unsigned BANK_ID = 0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        acc,
  input  logic        wr,
  input  reg_sel_t    sel,
  input  logic [31:0] wdata,
  input  logic [31:0] lock,
  input  logic [31:0] pins,
  output logic [31:0] out_q,
  output logic [31:0] dir_q,
  output logic [31:0] in_sync,
  output logic        ignored
);
  localparam logic [IDX_W-1:0] MY_IDX  = IDX_W'(BANK_ID);
  localparam logic [2:0]       MY_BANK = 3'(BANK_ID);

  logic [31:0] sync1, sync2, out_r, dir_r;
  logic        ctrl_hit, set_hit, clr_hit;
  logic [4:0]  pos;

  assign pos      = pin_pos(sel.idx);
  assign ctrl_hit = acc && wr && (sel.kind == RK_CTRL) && (pin_bank(sel.idx) == MY_BANK);
  assign set_hit  = acc && wr && (sel.kind == RK_SET) && (sel.idx == MY_IDX);
  assign clr_hit  = acc && wr && (sel.kind == RK_CLR) && (sel.idx == MY_IDX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
      out_r <= '0;
      dir_r <= '1;
    end else begin
      sync1 <= pins;
      sync2 <= sync1;
      if (set_hit) out_r <= apply_set(out_r, wdata, lock);
      else if (clr_hit) out_r <= apply_clr(out_r, wdata, lock);
      if (ctrl_hit && !lock[pos]) dir_r[pos] <= wdata[0];
    end
  end

  assign ignored = (ctrl_hit && lock[pos]) || ((set_hit || clr_hit) && |(wdata & lock));
  assign out_q   = out_r;
  assign dir_q   = dir_r;
  assign in_sync = sync2;
endmodule

// File: rtl/gpio_lockbank_regs.sv
module gpio_lockbank_regs
  import gpio_lockbank_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 8
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  bus_en,
  input  logic                                  bus_wr,
  input  logic [ADDR_W-1:0]                     bus_addr,
  input  logic [31:0]                           bus_wdata,
  output logic [31:0]                           bus_rdata,
  input  logic [NUM_BANKS*PINS_PER_BANK-1:0]    pin_in,
  output logic [NUM_BANKS*PINS_PER_BANK-1:0]    pin_out,
  output logic [NUM_BANKS*PINS_PER_BANK-1:0]    pin_oe
);
  localparam int unsigned NP    = NUM_BANKS * PINS_PER_BANK;
  localparam int unsigned PIN_W = $clog2(NP);

  reg_sel_t       sel;
  logic [NP-1:0]  lock_bits, out_bits, dir_bits, in_bits;
  logic           key_armed, lock_take, lock_drop;
  logic [NUM_BANKS-1:0] bank_ignored;
  logic           locked_write_ignored;
  logic [31:0]    rd_next, rdata_q;

  assign sel = decode_addr(bus_addr, NUM_BANKS);

  gpio_lockbank_guard #(.NUM_BANKS(NUM_BANKS)) u_guard (
    .clk(clk), .rst_n(rst_n), .acc(bus_en), .wr(bus_wr), .sel(sel),
    .wdata(bus_wdata), .lock_bits(lock_bits), .armed(key_armed),
    .lock_take(lock_take), .lock_drop(lock_drop)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    gpio_lockbank_bank #(.BANK_ID(b)) u_bank (
      .clk(clk), .rst_n(rst_n), .acc(bus_en), .wr(bus_wr), .sel(sel),
      .wdata(bus_wdata),
      .lock(lock_bits[b*PINS_PER_BANK +: PINS_PER_BANK]),
      .pins(pin_in[b*PINS_PER_BANK +: PINS_PER_BANK]),
      .out_q(out_bits[b*PINS_PER_BANK +: PINS_PER_BANK]),
      .dir_q(dir_bits[b*PINS_PER_BANK +: PINS_PER_BANK]),
      .in_sync(in_bits[b*PINS_PER_BANK +: PINS_PER_BANK]),
      .ignored(bank_ignored[b])
    );
  end

  // Event wire for the checker: some write bounced off a lock bit.
  assign locked_write_ignored = |bank_ignored;

  always_comb begin
    rd_next = '0;
    if (sel.kind == RK_CTRL) rd_next = {31'b0, dir_bits[sel.idx[PIN_W-1:0]]};
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (sel.idx == IDX_W'(b)) begin
        case (sel.kind)
          RK_OUTST: rd_next = out_bits[b*PINS_PER_BANK +: PINS_PER_BANK];
          RK_INST:  rd_next = in_bits[b*PINS_PER_BANK +: PINS_PER_BANK];
          RK_LOCK:  rd_next = lock_bits[b*PINS_PER_BANK +: PINS_PER_BANK];
          default:  ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rdata_q <= '0;
    else if (bus_en && !bus_wr) rdata_q <= rd_next;
  end

  assign bus_rdata = rdata_q;
  assign pin_out   = out_bits;
  assign pin_oe    = ~dir_bits;
endmodule

// File: rtl/gpio_lockbank_chk.sv
module gpio_lockbank_chk #(
  parameter int unsigned NP = 256
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_en,
  input logic          bus_wr,
  input logic [11:0]   bus_addr,
  input logic [31:0]   bus_wdata,
  input logic [NP-1:0] pin_out,
  input logic [NP-1:0] pin_oe,
  input logic [NP-1:0] lock_bits,
  input logic          armed,
  input logic          lock_take,
  input logic          locked_write_ignored
);
  logic past_ok;
  logic key_wr, lock_wr, setclr_wr, ctrl_wr;

  always_ff @(posedge clk) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  assign key_wr    = bus_en && bus_wr && bus_addr[11:2] == 10'h148 && bus_wdata == 32'h00a5a501;
  assign lock_wr   = bus_en && bus_wr && bus_addr[11:5] == 7'h28;
  assign setclr_wr = bus_en && bus_wr && (bus_addr[11:5] == 7'h02 || bus_addr[11:5] == 7'h03);
  assign ctrl_wr   = bus_en && bus_wr && bus_addr >= 12'h100 && bus_addr < 12'h500;

  assert_key_arms_R2: assert property (@(posedge clk) disable iff (!rst_n)
    key_wr |=> armed);

  assert_access_disarms_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && !key_wr) |=> !armed);

  assert_lock_needs_key_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && lock_bits != $past(lock_bits)) |-> $past(armed && lock_wr));

  assert_take_only_when_armed_R3: assert property (@(posedge clk) disable iff (!rst_n)
    lock_take |-> (armed && lock_wr));

  assert_locked_out_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> (((pin_out ^ $past(pin_out)) & $past(lock_bits)) == '0));

  assert_locked_oe_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> (((pin_oe ^ $past(pin_oe)) & $past(lock_bits)) == '0));

  assert_ignore_means_locked_R10: assert property (@(posedge clk) disable iff (!rst_n)
    locked_write_ignored |-> (bus_en && bus_wr && lock_bits != '0));

  assert_out_by_setclr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && pin_out != $past(pin_out)) |-> $past(setclr_wr));

  assert_oe_by_ctrl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && pin_oe != $past(pin_oe)) |-> $past(ctrl_wr));
endmodule

bind gpio_lockbank_regs gpio_lockbank_chk #(.NP(NP)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .pin_out(pin_out),
  .pin_oe(pin_oe), .lock_bits(lock_bits), .armed(key_armed),
  .lock_take(lock_take), .locked_write_ignored(locked_write_ignored)
);

// File: tb/gpio_lockbank_regs_test.sv
`timescale 1ns/1ps
module gpio_lockbank_regs_test;
  localparam int NB = 8;
  localparam int NP = NB * 32;
  localparam logic [31:0] KEY = 32'h00a5a501;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_en = 1'b0, bus_wr = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NP-1:0] pin_in = '0;
  logic [NP-1:0] pin_out, pin_oe;

  always #2.5 clk = ~clk;

  gpio_lockbank_regs #(.NUM_BANKS(NB)) uut (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  int checks = 0, errors = 0;
  logic [NP-1:0] m_dir, m_out, m_lock;
  bit m_armed;
  logic [31:0] last_rd;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_read(input logic [11:0] a);
    int b, p;
    b = int'(a[4:2]);
    if (a < 12'h020) return m_out[b*32 +: 32];
    if (a < 12'h040) return pin_in[b*32 +: 32];
    if (a >= 12'h100 && a < 12'h500) begin
      p = (int'(a) - 256) / 4;
      return {31'b0, m_dir[p]};
    end
    if (a >= 12'h500 && a < 12'h520) return m_lock[b*32 +: 32];
    return 32'h0;
  endfunction

  task automatic model_write(input logic [11:0] a, input logic [31:0] d);
    int b, p;
    bit nxt;
    b = int'(a[4:2]);
    nxt = (a == 12'h520 && d == KEY);
    if (a >= 12'h500 && a < 12'h520 && m_armed) m_lock[b*32 +: 32] = d;
    if (a >= 12'h100 && a < 12'h500) begin
      p = (int'(a) - 256) / 4;
      if (!m_lock[p]) m_dir[p] = d[0];
    end
    if (a >= 12'h040 && a < 12'h060) m_out[b*32 +: 32] = m_out[b*32 +: 32] | (d & ~m_lock[b*32 +: 32]);
    if (a >= 12'h060 && a < 12'h080) m_out[b*32 +: 32] = m_out[b*32 +: 32] & ~(d & ~m_lock[b*32 +: 32]);
    m_armed = nxt;
  endtask

  task automatic access(input bit wr, input logic [11:0] a, input logic [31:0] d,
                        output logic [31:0] rd);
    @(negedge clk);
    bus_en = 1'b1; bus_wr = wr; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_wr = 1'b0;
    rd = bus_rdata;
  endtask

  task automatic check_ports(input string req);
    for (int b = 0; b < NB; b++) begin
      check(req, pin_out[b*32 +: 32], m_out[b*32 +: 32]);
      check(req, pin_oe[b*32 +: 32], ~m_dir[b*32 +: 32]);
    end
  endtask

  task automatic wr_op(input logic [11:0] a, input logic [31:0] d);
    logic [31:0] rd;
    access(1'b1, a, d, rd);
    model_write(a, d);
    check("R11 rdata held across write", rd, last_rd);
  endtask

  task automatic rd_op(input logic [11:0] a, input string req);
    logic [31:0] rd, exp;
    exp = exp_read(a);
    access(1'b0, a, 32'h0, rd);
    m_armed = 1'b0;
    check(req, rd, exp);
    last_rd = rd;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    void'($urandom(32'd7331));
    m_dir = '1; m_out = '0; m_lock = '1; m_armed = 0; last_rd = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 rdata after reset", bus_rdata, 32'h0);
    check_ports("R1 reset ports");
    rd_op(12'h500, "R1 R4 lock bank0 after reset");
    rd_op(12'h51C, "R1 R4 lock bank7 after reset");
    rd_op(12'h114, "R1 R5 pin5 is input after reset");

    // R10 writes to locked pins ignored
    wr_op(12'h10C, 32'h0);
    wr_op(12'h040, 32'hFFFF_FFFF);
    check_ports("R10 locked pins unchanged");
    rd_op(12'h10C, "R10 locked pin3 direction read");

    // R3 lock write without key, after a read, after a wrong key
    wr_op(12'h500, 32'h0);
    rd_op(12'h500, "R3 lock write without key dropped");
    wr_op(12'h520, KEY);
    rd_op(12'h000, "R8 out status bank0");
    wr_op(12'h500, 32'h0);
    rd_op(12'h500, "R3 read between key and lock write");
    wr_op(12'h520, KEY ^ 32'h1);
    wr_op(12'h500, 32'h0);
    rd_op(12'h500, "R3 wrong key value");

    // R2 key arms one lock write only
    wr_op(12'h520, KEY);
    wr_op(12'h500, 32'h0);
    rd_op(12'h500, "R2 armed lock write taken");
    wr_op(12'h500, 32'hFFFF_FFFF);
    rd_op(12'h500, "R2 second lock write dropped");

    // R5 direction
    wr_op(12'h10C, 32'h0);
    check_ports("R5 pin3 output enable");
    rd_op(12'h10C, "R5 pin3 direction readback");
    wr_op(12'h1A0, 32'h0);
    rd_op(12'h1A0, "R10 pin40 locked in bank1");

    // R6 R7 R8
    wr_op(12'h040, 32'h0000_00F0);
    wr_op(12'h060, 32'h0000_0030);
    rd_op(12'h000, "R6 R7 set then clear");
    wr_op(12'h000, 32'hFFFF_FFFF);
    rd_op(12'h000, "R8 write to out status ignored");
    check_ports("R8 ports after status write");

    // R10 partial lock
    wr_op(12'h520, KEY);
    wr_op(12'h500, 32'h0000_0080);
    wr_op(12'h060, 32'h0000_00FF);
    rd_op(12'h000, "R10 locked bit7 survives clear");
    wr_op(12'h040, 32'h0000_0101);
    rd_op(12'h000, "R10 set past locked bit");

    // R9 synchronizer latency
    pin_in[64 +: 32] = 32'hA5C3_0F1E;
    access(1'b0, 12'h028, 32'h0, rd);
    m_armed = 0;
    check("R9 first slot still old", rd, 32'h0);
    access(1'b0, 12'h028, 32'h0, rd);
    check("R9 second slot new value", rd, 32'hA5C3_0F1E);
    last_rd = rd;

    // R11 unmapped
    rd_op(12'h600, "R11 unmapped read");
    rd_op(12'h0C0, "R11 gap read");
    rd_op(12'h520, "R11 key register read");
    rd_op(12'h040, "R11 set port read");
    wr_op(12'h600, 32'hFFFF_FFFF);
    check_ports("R11 unmapped write no effect");

    // unlock everything, then random traffic
    for (int b = 0; b < NB; b++) begin
      wr_op(12'h520, KEY);
      wr_op(12'(12'h500 + b*4), 32'h0);
    end
    for (int i = 0; i < 3000; i++) begin
      int op, b;
      logic [31:0] d;
      op = int'($urandom_range(0, 7));
      b  = int'($urandom_range(0, NB-1));
      d  = $urandom;
      case (op)
        0: begin
          wr_op(12'h520, KEY);
          if ($urandom_range(0, 9) < 7) begin
            case ($urandom_range(0, 2))
              0: d = 32'h0;
              1: d = 32'hFFFF_FFFF;
              default: ;
            endcase
            wr_op(12'(12'h500 + b*4), d);
          end
        end
        1: wr_op(12'(12'h100 + $urandom_range(0, NP-1)*4), d);
        2: wr_op(12'(12'h040 + b*4), d);
        3: wr_op(12'(12'h060 + b*4), d);
        4: begin
          case ($urandom_range(0, 3))
            0: rd_op(12'(12'h000 + b*4), "R8 random out status");
            1: rd_op(12'(12'h020 + b*4), "R9 random in status");
            2: rd_op(12'(12'h100 + $urandom_range(0, NP-1)*4), "R5 random direction");
            default: rd_op(12'(12'h500 + b*4), "R4 random lock word");
          endcase
        end
        5: begin
          pin_in[b*32 +: 32] = d;
          repeat (3) @(negedge clk);
        end
        6: begin
          wr_op(12'h520, d);
          wr_op(12'(12'h500 + b*4), ~d);
        end
        default: wr_op(12'(12'h500 + b*4), d);
      endcase
      check_ports("R6 R7 R10 random ports");
    end
    for (int b = 0; b < NB; b++) rd_op(12'(12'h500 + b*4), "R2 R3 final lock words");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule